// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out the atomic memory instructions of a small 64-bit register-machine instruction set. It works against a single-port, 64-bit-wide word memory. A decoder outside the unit hands over one decoded request with these fields:

- the access size;
- an 8-bit operation immediate;
- the base register value and a signed 16-bit displacement;
- the source register value and the value of register zero.

The unit reads the addressed word and computes the new value. It stores that value back while it keeps the memory port locked, so no other master can get in between the read and the write. It then reports what the register file must write back.

The supported operations are add, or, and, and exclusive-or, each with or without fetch of the old value. There are also an unconditional exchange and a compare-exchange that compares against register zero. Byte and halfword requests are refused. Unknown immediates are refused. Misaligned addresses are refused. When the 32-bit ALU mode input is low, every 32-bit request except the legacy plain add (immediate zero) is refused. A refused request never touches memory.

Top module: `atom_rmw_unit`

## Requirements
- R1: The byte address is `req_base` plus `req_off` sign-extended to 64 bits. `mem_addr` carries byte address bits [ADDR_W+2:3], the index of the 64-bit word.
- R2: The basic operations store memory-value OP source back to the same word. The immediates are add 0x00, or 0x40, and 0x50 and xor 0xa0. Without fetch, `rsp_wb_en` stays 0.
- R3: Setting immediate bit 0 (0x01, 0x41, 0x51, 0xa1) makes a basic operation also return the old memory value with `rsp_wb_sel`=0, which selects the source register.
- R4: Exchange (0xe1) stores the source value and returns the old memory value with `rsp_wb_sel`=0.
- R5: Compare-exchange (0xf1) stores the source value only when the old memory value equals `req_r0`. It always returns the old value with `rsp_wb_sel`=1, which selects register zero.
- R6: `req_size` 0 (byte) and 1 (halfword) give a response with `rsp_illegal`=1, no writeback and no memory access. Size 2 is 32-bit and size 3 is 64-bit.
- R7: When `alu32_en`=0, a 32-bit request is legal only with immediate 0x00. Any immediate outside the ten listed values is illegal for either size.
- R8: A 32-bit operation uses the lane selected by address bit 2 (1 = upper half). Byte enables are 0xF0 or 0x0F. Only the low 32 bits of the operands take part, and the returned old value is zero-extended.
- R9: A legal request passes through read, compute, write and respond, so `rsp_valid` comes 4 cycles after acceptance. `busy` is high from acceptance until the response. `mem_lock` is high from the read through the write. `rsp_valid` lasts one cycle.
- R10: An address that is not a multiple of the access size gives `rsp_misalign`=1, no writeback and no memory access. An illegal request answers one cycle after acceptance, and illegal takes priority over misalignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present, taken when busy is low |
| req_size | input | 2 | 0 byte, 1 half, 2 word32, 3 word64 |
| req_imm | input | 8 | Operation immediate |
| req_base | input | 64 | Base register value |
| req_off | input | 16 | Signed displacement |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | Register zero value |
| alu32_en | input | 1 | 32-bit ALU mode enabled |
| busy | output | 1 | Operation in progress |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Word index |
| mem_be | output | 8 | Byte enables for writes |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after a read strobe |
| mem_lock | output | 1 | Port held for the atomic sequence |
| rsp_valid | output | 1 | Response strobe |
| rsp_illegal | output | 1 | Illegal-instruction error |
| rsp_misalign | output | 1 | Alignment error |
| rsp_wb_en | output | 1 | Register writeback enable |
| rsp_wb_sel | output | 1 | 0 source register, 1 register zero |
| rsp_wb_data | output | 64 | Writeback value |

## Verification
The bench builds the unit with ADDR_W=6, which gives a 64-word memory model. With that depth a negative displacement from a mid-range base still lands inside the array, and both 32-bit lanes of a word can be reached. Because the array is this small, every write the unit makes can be counted. That makes it possible to check that refused requests and failed compare-exchanges leave memory alone.

// File: rtl/atom_pkg.sv
// Shared types for the atomic read-modify-write unit.
// Assumes a 64-bit data path; only the address width is a parameter.
package atom_pkg;
    localparam int XLEN = 64;
    localparam int BE_W = XLEN / 8;

    typedef enum logic [2:0] {
        OP_ADD, OP_OR, OP_AND, OP_XOR, OP_XCHG, OP_CMPX
    } atom_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_CALC, ST_WRITE, ST_RESP
    } atom_st_e;
endpackage

// File: rtl/atom_decode.sv
// Request decoder: forms the byte address, splits it into word index and lane,
// maps the immediate to an operation and judges legality and alignment.
// Assumes req fields are stable while it is sampled in the idle state.
module atom_decode
    import atom_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        size,
    input  logic [7:0]        imm,
    input  logic [XLEN-1:0]   base,
    input  logic [15:0]       off,
    input  logic              alu32_en,
    output atom_op_e          op,
    output logic              fetch,
    output logic              is32,
    output logic              illegal,
    output logic              misalign,
    output logic [ADDR_W-1:0] word_idx,
    output logic              lane_hi
);
    logic [XLEN-1:0] byte_addr;
    logic            bad_imm;

    // Effective address from base plus sign-extended displacement.
    always_comb byte_addr = base + {{(XLEN-16){off[15]}}, off};

    // Immediate to operation mapping; bit 0 carries the fetch flag.
    always_comb begin
        bad_imm = 1'b0;
        op      = OP_ADD;
        fetch   = imm[0];
        unique case (imm)
            8'h00, 8'h01: op = OP_ADD;
            8'h40, 8'h41: op = OP_OR;
            8'h50, 8'h51: op = OP_AND;
            8'ha0, 8'ha1: op = OP_XOR;
            8'he1:        op = OP_XCHG;
            8'hf1:        op = OP_CMPX;
            default:      bad_imm = 1'b1;
        endcase
    end

    // Legality and alignment judgement.
    always_comb begin
        is32     = (size == 2'd2);
        illegal  = bad_imm || (size < 2'd2) || (is32 && !alu32_en && imm != 8'h00);
        misalign = is32 ? (byte_addr[1:0] != 2'b00) : (byte_addr[2:0] != 3'b000);
        word_idx = byte_addr[ADDR_W+2:3];
        lane_hi  = byte_addr[2];
    end
endmodule

// File: rtl/atom_alu.sv
// Combinational compute stage: derives the new memory value, whether it is
// stored, and the register writeback from the old value and the operands.
// Assumes old_val is already lane-extracted and zero-extended for 32-bit use.
module atom_alu
    import atom_pkg::*;
(
    input  atom_op_e        op,
    input  logic            fetch,
    input  logic            is32,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] r0,
    output logic [XLEN-1:0] new_val,
    output logic            do_write,
    output logic            wb_en,
    output logic            wb_sel
);
    logic [XLEN-1:0] a_opnd, c_opnd, raw;

    // Narrow operands to the low half for 32-bit accesses.
    always_comb begin
        a_opnd = is32 ? {32'b0, src[31:0]} : src;
        c_opnd = is32 ? {32'b0, r0[31:0]}  : r0;
    end

    // Operation result and store decision.
    always_comb begin
        unique case (op)
            OP_ADD:  raw = old_val + a_opnd;
            OP_OR:   raw = old_val | a_opnd;
            OP_AND:  raw = old_val & a_opnd;
            OP_XOR:  raw = old_val ^ a_opnd;
            default: raw = a_opnd;
        endcase
        new_val  = is32 ? {32'b0, raw[31:0]} : raw;
        do_write = (op != OP_CMPX) || (old_val == c_opnd);
        wb_en    = fetch || (op == OP_XCHG) || (op == OP_CMPX);
        wb_sel   = (op == OP_CMPX);
    end
endmodule

// File: rtl/atom_rmw_unit.sv
// Atomic read-modify-write unit top: sequences idle, read, compute, write,
// respond against a single-port memory with one-cycle read latency, holding
// mem_lock across the read-to-write window. Refused requests skip memory.
module atom_rmw_unit
    import atom_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_size,
    input  logic [7:0]        req_imm,
    input  logic [63:0]       req_base,
    input  logic [15:0]       req_off,
    input  logic [63:0]       req_src,
    input  logic [63:0]       req_r0,
    input  logic              alu32_en,
    output logic              busy,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_be,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    output logic              mem_lock,
    output logic              rsp_valid,
    output logic              rsp_illegal,
    output logic              rsp_misalign,
    output logic              rsp_wb_en,
    output logic              rsp_wb_sel,
    output logic [63:0]       rsp_wb_data
);
    atom_st_e          st_q;
    atom_op_e          d_op, op_q;
    logic              d_fetch, d_is32, d_ill, d_mis, d_hi;
    logic [ADDR_W-1:0] d_idx, idx_q;
    logic              fetch_q, is32_q, hi_q, ill_q, mis_q;
    logic [XLEN-1:0]   src_q, r0_q, old_lane, new_val, new_q, old_q;
    logic              a_wr, a_wben, a_sel, wr_q, wben_q, sel_q;
    logic              accept;

    atom_decode #(.ADDR_W(ADDR_W)) u_dec (
        .size(req_size), .imm(req_imm), .base(req_base), .off(req_off),
        .alu32_en(alu32_en), .op(d_op), .fetch(d_fetch), .is32(d_is32),
        .illegal(d_ill), .misalign(d_mis), .word_idx(d_idx), .lane_hi(d_hi)
    );

    // Lane extraction of the word just read.
    always_comb begin
        if (is32_q) old_lane = {32'b0, hi_q ? mem_rdata[63:32] : mem_rdata[31:0]};
        else        old_lane = mem_rdata;
    end

    atom_alu u_alu (
        .op(op_q), .fetch(fetch_q), .is32(is32_q), .old_val(old_lane),
        .src(src_q), .r0(r0_q), .new_val(new_val), .do_write(a_wr),
        .wb_en(a_wben), .wb_sel(a_sel)
    );

    always_comb accept = req_valid && (st_q == ST_IDLE);

    // State sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else begin
            unique case (st_q)
                ST_IDLE:  if (accept) st_q <= (d_ill || d_mis) ? ST_RESP : ST_READ;
                ST_READ:  st_q <= ST_CALC;
                ST_CALC:  st_q <= ST_WRITE;
                ST_WRITE: st_q <= ST_RESP;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_ADD; fetch_q <= 1'b0; is32_q <= 1'b0; hi_q <= 1'b0;
            ill_q <= 1'b0; mis_q <= 1'b0; idx_q <= '0; src_q <= '0; r0_q <= '0;
        end else if (accept) begin
            op_q <= d_op; fetch_q <= d_fetch; is32_q <= d_is32; hi_q <= d_hi;
            ill_q <= d_ill; mis_q <= d_mis && !d_ill; idx_q <= d_idx;
            src_q <= req_src; r0_q <= req_r0;
        end
    end

    // Compute result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_q <= '0; old_q <= '0; wr_q <= 1'b0; wben_q <= 1'b0; sel_q <= 1'b0;
        end else if (accept) begin
            wr_q <= 1'b0; wben_q <= 1'b0; sel_q <= 1'b0; old_q <= '0;
        end else if (st_q == ST_CALC) begin
            new_q <= new_val; old_q <= old_lane; wr_q <= a_wr;
            wben_q <= a_wben; sel_q <= a_sel;
        end
    end

    // Memory port and response outputs.
    always_comb begin
        busy         = (st_q != ST_IDLE);
        mem_lock     = (st_q == ST_READ) || (st_q == ST_CALC) || (st_q == ST_WRITE);
        mem_we       = (st_q == ST_WRITE) && wr_q;
        mem_en       = (st_q == ST_READ) || mem_we;
        mem_addr     = idx_q;
        mem_wdata    = is32_q ? {new_q[31:0], new_q[31:0]} : new_q;
        mem_be       = is32_q ? (hi_q ? 8'hf0 : 8'h0f) : 8'hff;
        rsp_valid    = (st_q == ST_RESP);
        rsp_illegal  = rsp_valid && ill_q;
        rsp_misalign = rsp_valid && mis_q;
        rsp_wb_en    = rsp_valid && wben_q && !ill_q && !mis_q;
        rsp_wb_sel   = sel_q;
        rsp_wb_data  = old_q;
    end
endmodule

// File: rtl/atom_rmw_sva.sv
// Protocol checker for atom_rmw_unit; observes ports only.
module atom_rmw_sva #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_size,
    input logic [7:0]        req_imm,
    input logic [63:0]       req_base,
    input logic [15:0]       req_off,
    input logic [63:0]       req_src,
    input logic [63:0]       req_r0,
    input logic              alu32_en,
    input logic              busy,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_be,
    input logic [63:0]       mem_wdata,
    input logic [63:0]       mem_rdata,
    input logic              mem_lock,
    input logic              rsp_valid,
    input logic              rsp_illegal,
    input logic              rsp_misalign,
    input logic              rsp_wb_en,
    input logic              rsp_wb_sel,
    input logic [63:0]       rsp_wb_data
);
    // Any memory access happens under the lock.
    p_access_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> mem_lock);
    // A read is followed by a locked, idle-port compute cycle.
    p_read_then_calc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (mem_lock && !mem_en));
    // Lock release hands over to the response.
    p_unlock_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> rsp_valid);
    // Response lasts a single cycle.
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // Byte and halfword requests are answered as illegal next cycle.
    p_small_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_size < 2'd2) |=> (rsp_valid && rsp_illegal && !mem_en));
    // Errors never write back.
    p_err_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_illegal || rsp_misalign) |-> !rsp_wb_en);
    // Register zero is the target only for compare-exchange (immediate 0xf1).
    p_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_imm != 8'hf1) |=> !rsp_wb_sel);
endmodule

bind atom_rmw_unit atom_rmw_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/tb_atom_rmw_unit.sv
module tb_atom_rmw_unit;
    localparam int AW = 6;

    typedef struct packed {
        logic        ill;
        logic        mis;
        logic        wben;
        logic        sel;
        logic [63:0] data;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, alu32_en = 1'b1;
    logic [1:0] req_size = 2'd3;
    logic [7:0] req_imm = 8'h00;
    logic [63:0] req_base = '0, req_src = '0, req_r0 = '0;
    logic [15:0] req_off = '0;
    logic busy, mem_en, mem_we, mem_lock, rsp_valid, rsp_illegal, rsp_misalign;
    logic rsp_wb_en, rsp_wb_sel;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_be;
    logic [63:0] mem_wdata, mem_rdata, rsp_wb_data;

    logic [63:0] mem [64];
    int wr_cnt = 0, n_chk = 0, n_bad = 0, n_rsp = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    atom_rmw_unit #(.ADDR_W(AW)) dut (.*);

    // Memory model with one-cycle read latency and byte enables.
    always_ff @(posedge clk) begin
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
        if (mem_en && mem_we) begin
            for (int b = 0; b < 8; b++)
                if (mem_be[b]) mem[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard on each response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            n_rsp++;
            if (sb.size() == 0) check("R9 unexpected response", 1, 0);
            else begin
                e = sb.pop_front();
                check("R6/R7 illegal flag", rsp_illegal, e.ill);
                check("R10 misalign flag", rsp_misalign, e.mis);
                check("R3 writeback enable", rsp_wb_en, e.wben);
                if (e.wben) begin
                    check("R5 writeback select", rsp_wb_sel, e.sel);
                    check("R4/R8 writeback data", rsp_wb_data, e.data);
                end
            end
        end
    end

    // Driver: model, push expectation, issue, then check memory and latency.
    task automatic do_op(input string tag, input logic [1:0] sz, input logic [7:0] imm,
                         input logic [63:0] base, input logic [15:0] off,
                         input logic [63:0] src, input logic [63:0] r0);
        logic [63:0] addr, oldw, oldv, a, c, nv, neww;
        logic ill, mis, is32, known, wr;
        exp_t e;
        int lat, w0, r0cnt;
        addr = base + {{48{off[15]}}, off};
        is32 = (sz == 2'd2);
        known = imm inside {8'h00,8'h01,8'h40,8'h41,8'h50,8'h51,8'ha0,8'ha1,8'he1,8'hf1};
        ill = !known || sz < 2 || (is32 && !alu32_en && imm != 8'h00);
        mis = !ill && (is32 ? addr[1:0] != 0 : addr[2:0] != 0);
        oldw = mem[addr[AW+2:3]];
        oldv = is32 ? {32'b0, addr[2] ? oldw[63:32] : oldw[31:0]} : oldw;
        a = is32 ? {32'b0, src[31:0]} : src;
        c = is32 ? {32'b0, r0[31:0]} : r0;
        case (imm[7:4])
            4'h0: nv = oldv + a;
            4'h4: nv = oldv | a;
            4'h5: nv = oldv & a;
            4'ha: nv = oldv ^ a;
            default: nv = a;
        endcase
        wr = !ill && !mis && (imm != 8'hf1 || oldv == c);
        neww = oldw;
        if (wr) begin
            if (!is32) neww = nv;
            else if (addr[2]) neww[63:32] = nv[31:0];
            else neww[31:0] = nv[31:0];
        end
        e.ill = ill; e.mis = mis; e.wben = !ill && !mis && imm[0];
        e.sel = (imm == 8'hf1); e.data = oldv;
        sb.push_back(e);
        w0 = wr_cnt; r0cnt = n_rsp;
        @(negedge clk);
        req_valid = 1; req_size = sz; req_imm = imm; req_base = base;
        req_off = off; req_src = src; req_r0 = r0;
        lat = 0;
        do begin
            @(negedge clk); lat++;
            req_valid = 0;
            if (lat == 1) check({tag, " R9 busy after accept"}, busy, 1);
        end while (!rsp_valid && lat < 20);
        check({tag, " R9/R10 response latency"}, lat, (ill || mis) ? 1 : 4);
        @(negedge clk);
        check({tag, " R2/R5/R6 memory word"}, mem[addr[AW+2:3]], neww);
        check({tag, " R5/R6/R10 write count"}, wr_cnt - w0, wr ? 1 : 0);
        check({tag, " R9 one response"}, n_rsp - r0cnt, 1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 64'h1111_0000_0000_0000 * i + i;
        repeat (3) @(negedge clk);
        check("R9 reset busy", busy, 0);
        check("R9 reset rsp_valid", rsp_valid, 0);
        check("R9 reset mem_en", mem_en, 0);
        rst_n = 1;
        mem[31] = 64'd10;
        do_op("R1 R2 add neg offset", 2'd3, 8'h00, 64'h100, 16'hfff8, 64'd5, 0);
        check("R1 address word 31", mem[31], 64'd15);
        do_op("R3 or fetch", 2'd3, 8'h41, 64'h40, 0, 64'hf0, 0);
        do_op("R3 and fetch", 2'd3, 8'h51, 64'h48, 0, 64'h0ff0_ff00_ff00_ffff, 0);
        do_op("R2 xor", 2'd3, 8'ha0, 64'h50, 0, 64'hffff_0000_ffff_0000, 0);
        do_op("R4 xchg", 2'd3, 8'he1, 64'h58, 0, 64'hdead_beef_0123_4567, 0);
        mem[12] = 64'h77;
        do_op("R5 cmpx match", 2'd3, 8'hf1, 64'h60, 0, 64'h99, 64'h77);
        do_op("R5 cmpx mismatch", 2'd3, 8'hf1, 64'h60, 0, 64'h55, 64'h77);
        do_op("R6 byte", 2'd0, 8'h00, 64'h68, 0, 64'h1, 0);
        do_op("R6 half", 2'd1, 8'h01, 64'h68, 0, 64'h1, 0);
        mem[14] = 64'h0000_0005_ffff_ffff;
        do_op("R8 add32 lo carry", 2'd2, 8'h01, 64'h70, 0, 64'hffff_ffff_0000_0002, 0);
        do_op("R8 xor32 hi", 2'd2, 8'ha1, 64'h74, 0, 64'h0000_0000_0000_000f, 0);
        do_op("R7 unknown imm", 2'd3, 8'h33, 64'h78, 0, 64'h1, 0);
        alu32_en = 0;
        do_op("R7 legacy add32", 2'd2, 8'h00, 64'h7c, 0, 64'h3, 0);
        do_op("R7 fetch32 refused", 2'd2, 8'h01, 64'h7c, 0, 64'h3, 0);
        alu32_en = 1;
        do_op("R10 misalign64", 2'd3, 8'h00, 64'h84, 0, 64'h1, 0);
        do_op("R10 misalign32", 2'd2, 8'he1, 64'h82, 0, 64'h1, 0);
        do_op("R10 illegal wins", 2'd0, 8'h00, 64'h83, 0, 64'h1, 0);
        check("R9 scoreboard drained", sb.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule